// File: doc/BRIEF.md
# HDLC Receive Frame Length Guard

This block sits in an HDLC receive path after flag detection and bit destuffing, and before the logic that writes frame bytes into receive buffers. It watches three strobes: an opening flag, a byte-valid and a closing flag. It also takes a programmable ceiling on the number of in-frame bytes, and it gates the buffer write enable so that bytes beyond that ceiling never reach memory.

The ceiling is captured into a down-counter when the opening flag arrives. Each accepted byte uses up one unit. Once the counter is empty, the remaining bytes of that frame are dropped without ending the frame. The block then waits for the real closing flag. One cycle after that flag it presents a status word for one clock. The word holds a length-error bit and the count of bytes that were written.

Within one clock the events are taken in a fixed order. A byte present in the cycle is judged against the frame that was open before the cycle. The closing flag then ends that frame, and the opening flag then starts the next one. CRC, destuffing and buffer management are handled elsewhere.

Top module: `hdlc_len_guard`

## Requirements
- R1: After reset no frame is open, `status_vld_o` is 0 and `byte_wr_o` stays 0 even when `byte_vld_i` is 1.
- R2: The ceiling `max_len_i` is sampled only in the cycle `sof_i` is 1. Changing `max_len_i` while a frame is open has no effect on that frame.
- R3: While fewer bytes than the ceiling have been accepted in the open frame, a byte with `byte_vld_i` = 1 raises `byte_wr_o` combinationally in the same cycle.
- R4: Once the ceiling has been reached, every further byte of that frame sees `byte_wr_o` = 0 until the frame closes.
- R5: An `eof_i` while a frame is open makes `status_vld_o` 1 for exactly one cycle, in the cycle after `eof_i`. `status_len_o` then carries the number of bytes written in the frame.
- R6: A frame whose byte count equals the ceiling is reported with `status_lg_o` = 0 and `status_len_o` equal to the ceiling.
- R7: A frame with more bytes than the ceiling is reported with `status_lg_o` = 1, and `status_len_o` saturates at the ceiling.
- R8: Bytes and `eof_i` that arrive while no frame is open produce no write and no status.
- R9: An `sof_i` while a frame is open abandons that frame without a status report. It reloads the ceiling, zeroes the count and clears the length-error flag.
- R10: Within one cycle, a byte belongs to the frame open before that cycle, `eof_i` then closes it, and `sof_i` then opens a new frame.
- R11: With a ceiling of 0, every byte of the frame is dropped. The report shows length 0, with `status_lg_o` = 1 only if at least one byte arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| max_len_i | input | 16 | Maximum allowed in-frame byte count |
| sof_i | input | 1 | Opening flag seen |
| byte_vld_i | input | 1 | An in-frame byte is present |
| eof_i | input | 1 | Closing flag seen |
| byte_wr_o | output | 1 | Write enable for the current byte |
| status_vld_o | output | 1 | Status word valid, one cycle |
| status_lg_o | output | 1 | Frame exceeded the ceiling |
| status_len_o | output | 16 | Number of bytes written for the frame |

## Verification
Frames are sent with byte counts below, equal to and above the ceiling. Comparing these shows where the boundary sits: an off-by-one in the down-counter turns the exact-length frame into an error, or lets one extra byte through. A zero ceiling, a ceiling changed mid-frame and a maximum ceiling check the load path on their own. Restarted frames, strobes outside any frame and a cycle carrying byte, closing flag and opening flag together check the ordering rules that separate one frame's count from the next.

// File: rtl/hlg_pkg.sv
package hlg_pkg;

    // Frame tracking state shared by the control logic
    typedef struct packed {
        logic in_frame;
        logic viol;
    } hlg_frame_t;

    localparam int unsigned HLG_LEN_W = 16;

endpackage

// File: rtl/hlg_len_cnt.sv
module hlg_len_cnt #(
    parameter int unsigned LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LEN_W-1:0] lim_i,
    input  logic             take_i,
    output logic             room_o,
    output logic [LEN_W-1:0] cnt_now_o
);

    typedef struct packed {
        logic [LEN_W-1:0] rem;
        logic [LEN_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // A byte taken this cycle belongs to the frame open before the cycle
        if (take_i) begin
            st_d.rem = st_q.rem - LEN_W'(1);
            st_d.cnt = st_q.cnt + LEN_W'(1);
        end
        // An opening flag then starts a fresh budget
        if (load_i) begin
            st_d.rem = lim_i;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign room_o    = (st_q.rem != '0);
    assign cnt_now_o = take_i ? st_q.cnt + LEN_W'(1) : st_q.cnt;

    // R4
    take_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !load_i) |=> (st_q.rem == $past(st_q.rem) - LEN_W'(1)));

    // R2
    load_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (st_q.cnt == '0 && st_q.rem == $past(lim_i)));

endmodule

// File: rtl/hlg_frame_ctl.sv
module hlg_frame_ctl
    import hlg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sof_i,
    input  logic eof_i,
    input  logic byte_vld_i,
    input  logic room_i,
    output logic take_o,
    output logic close_o,
    output logic viol_now_o
);

    hlg_frame_t fr_d, fr_q;
    logic       over;

    assign take_o     = fr_q.in_frame & byte_vld_i & room_i;
    assign over       = fr_q.in_frame & byte_vld_i & ~room_i;
    assign close_o    = fr_q.in_frame & eof_i;
    assign viol_now_o = fr_q.viol | over;

    always_comb begin
        fr_d      = fr_q;
        fr_d.viol = fr_q.viol | over;
        if (eof_i) fr_d.in_frame = 1'b0;
        if (sof_i) begin
            fr_d.in_frame = 1'b1;
            fr_d.viol     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    // R9
    sof_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_i |=> (fr_q.in_frame && !fr_q.viol));

    // R7
    viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fr_q.viol) |-> $past(fr_q.in_frame && byte_vld_i && !room_i));

endmodule

// File: rtl/hlg_status.sv
module hlg_status #(
    parameter int unsigned LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    input  logic             lg_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             vld_o,
    output logic             lg_o,
    output logic [LEN_W-1:0] len_o
);

    typedef struct packed {
        logic             vld;
        logic             lg;
        logic [LEN_W-1:0] len;
    } stat_t;

    stat_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.vld = fire_i;
        if (fire_i) begin
            s_d.lg  = lg_i;
            s_d.len = len_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign vld_o = s_q.vld;
    assign lg_o  = s_q.lg;
    assign len_o = s_q.len;

    // R5
    held_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_i |=> ($stable(s_q.len) && !s_q.vld));

endmodule

// File: rtl/hdlc_len_guard.sv
module hdlc_len_guard
    import hlg_pkg::*;
#(
    parameter int unsigned LEN_W = HLG_LEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] max_len_i,
    input  logic             sof_i,
    input  logic             byte_vld_i,
    input  logic             eof_i,
    output logic             byte_wr_o,
    output logic             status_vld_o,
    output logic             status_lg_o,
    output logic [LEN_W-1:0] status_len_o
);

    logic             room;
    logic             take;
    logic             close;
    logic             viol_now;
    logic [LEN_W-1:0] cnt_now;

    hlg_frame_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sof_i      (sof_i),
        .eof_i      (eof_i),
        .byte_vld_i (byte_vld_i),
        .room_i     (room),
        .take_o     (take),
        .close_o    (close),
        .viol_now_o (viol_now)
    );

    hlg_len_cnt #(.LEN_W(LEN_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (sof_i),
        .lim_i     (max_len_i),
        .take_i    (take),
        .room_o    (room),
        .cnt_now_o (cnt_now)
    );

    hlg_status #(.LEN_W(LEN_W)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (close),
        .lg_i   (viol_now),
        .len_i  (cnt_now),
        .vld_o  (status_vld_o),
        .lg_o   (status_lg_o),
        .len_o  (status_len_o)
    );

    assign byte_wr_o = take;

    // R3
    wr_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_wr_o |-> byte_vld_i);

    // R8
    idle_eof_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_i && !close) |=> !status_vld_o);

endmodule

// File: tb/hdlc_len_guard_bench.sv
module hdlc_len_guard_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] max_len_i = '0;
    logic        sof_i = 1'b0, byte_vld_i = 1'b0, eof_i = 1'b0;
    logic        byte_wr_o, status_vld_o, status_lg_o;
    logic [15:0] status_len_o;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hdlc_len_guard u_hdlc_len_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .max_len_i    (max_len_i),
        .sof_i        (sof_i),
        .byte_vld_i   (byte_vld_i),
        .eof_i        (eof_i),
        .byte_wr_o    (byte_wr_o),
        .status_vld_o (status_vld_o),
        .status_lg_o  (status_lg_o),
        .status_len_o (status_len_o)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Drive one cycle from a negedge; wr is sampled before the posedge,
    // and the task returns at the next negedge.
    task automatic step(input logic s, input logic v, input logic e, output logic wr);
        sof_i = s; byte_vld_i = v; eof_i = e;
        #1 wr = byte_wr_o;
        @(negedge clk);
        sof_i = 1'b0; byte_vld_i = 1'b0; eof_i = 1'b0;
    endtask

    task automatic chk_status(input string tag, input int lg, input int len);
        chk({tag, " vld"}, int'(status_vld_o), 1);
        chk({tag, " lg"},  int'(status_lg_o), lg);
        chk({tag, " len"}, int'(status_len_o), len);
    endtask

    task automatic frame(input string tag, input int lim, input int n);
        logic wr;
        int   wrs = 0;
        int   exp_ok;
        max_len_i = 16'(lim);
        step(1'b1, 1'b0, 1'b0, wr);
        for (int i = 0; i < n; i++) begin
            step(1'b0, 1'b1, 1'b0, wr);
            chk({tag, " wr byte"}, int'(wr), (i < lim) ? 1 : 0);
            if (wr) wrs++;
        end
        step(1'b0, 1'b0, 1'b1, wr);
        exp_ok = (n < lim) ? n : lim;
        chk({tag, " wr total"}, wrs, exp_ok);
        chk_status(tag, (n > lim) ? 1 : 0, exp_ok);
        step(1'b0, 1'b0, 1'b0, wr);
        chk({tag, " R5 pulse ends"}, int'(status_vld_o), 0);
    endtask

    task automatic t_reset();
        logic wr;
        chk("R1 status after reset", int'(status_vld_o), 0);
        step(1'b0, 1'b1, 1'b0, wr);
        chk("R1 no write when idle", int'(wr), 0);
    endtask

    task automatic t_outside();
        logic wr;
        step(1'b0, 1'b1, 1'b0, wr);
        chk("R8 byte outside frame", int'(wr), 0);
        step(1'b0, 1'b1, 1'b1, wr);
        chk("R8 byte with eof outside", int'(wr), 0);
        chk("R8 no status outside", int'(status_vld_o), 0);
    endtask

    task automatic t_limit_change();
        logic wr;
        int   wrs = 0;
        max_len_i = 16'd3;
        step(1'b1, 1'b0, 1'b0, wr);
        max_len_i = 16'd100;
        for (int i = 0; i < 5; i++) begin
            step(1'b0, 1'b1, 1'b0, wr);
            if (wr) wrs++;
        end
        chk("R2 writes use sampled limit", wrs, 3);
        step(1'b0, 1'b0, 1'b1, wr);
        chk_status("R2 limit change", 1, 3);
    endtask

    task automatic t_restart();
        logic wr;
        max_len_i = 16'd3;
        step(1'b1, 1'b0, 1'b0, wr);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0, wr);
        chk("R9 overflow byte dropped", int'(wr), 0);
        step(1'b1, 1'b0, 1'b0, wr);
        chk("R9 no status on restart", int'(status_vld_o), 0);
        step(1'b0, 1'b1, 1'b0, wr);
        chk("R9 write after restart", int'(wr), 1);
        step(1'b0, 1'b1, 1'b0, wr);
        step(1'b0, 1'b0, 1'b1, wr);
        chk_status("R9 restarted frame", 0, 2);
    endtask

    task automatic t_same_cycle();
        logic wr;
        max_len_i = 16'd4;
        step(1'b1, 1'b0, 1'b0, wr);
        step(1'b0, 1'b1, 1'b0, wr);
        step(1'b0, 1'b1, 1'b0, wr);
        step(1'b1, 1'b1, 1'b1, wr);
        chk("R10 byte goes to old frame", int'(wr), 1);
        chk_status("R10 old frame", 0, 3);
        step(1'b0, 1'b1, 1'b0, wr);
        chk("R10 new frame open", int'(wr), 1);
        step(1'b0, 1'b0, 1'b1, wr);
        chk_status("R10 new frame", 0, 1);
        step(1'b0, 1'b1, 1'b0, wr);
        chk("R10 closed after eof", int'(wr), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        frame("R3 R5 under limit", 10, 4);
        frame("R6 exact limit", 6, 6);
        frame("R4 R7 over limit", 5, 9);
        frame("R11 zero limit with bytes", 0, 3);
        frame("R11 zero limit empty", 0, 0);
        frame("R3 large limit", 16'hFFFF, 20);
        t_outside();
        t_limit_change();
        t_restart();
        t_same_cycle();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule